// File: doc/BRIEF.md
# Programmable FIFO Flag Offset Bank

This block holds the two threshold offsets that a deep FIFO's flag logic compares against its fill level. One offset is for almost-empty and one is for almost-full. Each offset is 17 bits wide. It is kept as a low byte, a mid byte and a single top bit. The FIFO storage array and the flag comparators live outside this block, which drives both offsets to them as plain vectors.

The same control pins serve two purposes, and `ld` chooses between them. With `ld` high, the write and read enables become strobes for the FIFO memory. With `ld` low, they operate on the offset bank. The bank can be loaded in one of two ways, fixed when master reset is applied:

- **Parallel:** bytes written through a shared port, stepping through six slots in turn.
- **Serial:** one bit per clock into a 34-bit chain.

Both offsets can be read back one slot at a time whichever load method is in force. The level of `ld` during master reset picks one of two sets of default offsets. Write and read sides share a single clock.

Top module: `fifo_offset_bank`

## Requirements
- R1: While `mrst` is high at a clock edge, both offsets take their defaults and `dout` clears to 0. With `ld` low the default is 0x07F7F (top bit 0, mid byte 7F, low byte 7F). With `ld` high the default is 0x1FFFF. The parallel write slot and the parallel read slot both return to slot 0.
- R2: `serial_mode` takes the value of `load_serial` at a reset edge and keeps it until the next reset, whatever `load_serial` does meanwhile.
- R3: In parallel mode, a clock edge with `ld`=0, `wen_n`=0 and `ren_n`=1 writes `din` into the current write slot and then moves to the next slot.
  - Slot order: 0 empty[7:0], 1 empty[15:8], 2 empty[16] from `din[0]`, 3 full[7:0], 4 full[15:8], 5 full[16] from `din[0]`.
  - After slot 5 the write slot wraps to slot 0.
- R4: In serial mode, the parallel write condition of R3 leaves both offsets and the write slot unchanged.
- R5: A clock edge with `ld`=0, `ren_n`=0 and `wen_n`=1 loads `dout` with the current read slot and then moves the read slot on.
  - The read slots follow the same order as R3, and the read position moves independently of the write position.
  - The top-bit slots are returned zero-extended in `dout[0]`.
  - This works in either mode.
  - `dout` holds its value at every other edge.
- R6: In serial mode, a clock edge with `ld`=0, `wen_n`=1, `ren_n`=1 and `sen_n`=0 shifts the 34-bit chain {full, empty} one place toward empty bit 0, with `sin` entering full bit 16. The first of 34 bits shifted ends up in empty bit 0, and the last ends up in full bit 16.
- R7: In parallel mode, the serial shift condition of R6 leaves both offsets unchanged.
- R8: `mem_we` equals `ld & ~wen_n` and `mem_re` equals `ld & ~ren_n`, both combinational. Both are forced low while `mrst` is high. Memory operations leave the offsets unchanged.
- R9: With `ld` low, two input patterns change nothing: `wen_n` and `ren_n` both high with `sen_n` high, and `wen_n` and `ren_n` both low. The offsets, `dout` and both slot positions keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared write/read clock |
| mrst | input | 1 | Synchronous master reset, active high |
| ld | input | 1 | Selects offset-bank access (low) or memory access (high) |
| wen_n | input | 1 | Write enable, active low |
| ren_n | input | 1 | Read enable, active low |
| sen_n | input | 1 | Serial shift enable, active low |
| load_serial | input | 1 | Load method sampled at reset: 1 serial, 0 parallel |
| sin | input | 1 | Serial data bit |
| din | input | 8 | Parallel write byte |
| dout | output | 8 | Parallel read-back byte |
| mem_we | output | 1 | FIFO memory write strobe |
| mem_re | output | 1 | FIFO memory read strobe |
| serial_mode | output | 1 | Latched load method |
| empty_ofs | output | 17 | Almost-empty offset |
| full_ofs | output | 17 | Almost-full offset |

## Verification
The hardest state to reach is the wrap of each rotating pointer. Reaching it takes six consecutive accesses of the same kind with no reset between them. The bench therefore runs twelve writes, and then twelve reads, back to back. Each write uses a distinct byte, so a slot that is skipped or repeated shows up in the offsets or in `dout`.

The second hard case is a full 34-bit serial fill. The bench shifts in a pattern that has no symmetry and compares the whole chain after every bit. It then repeats the reset sweep with each level of `ld` and each load method, and tries every disallowed operation in both modes.

// File: rtl/fifo_offset_bank.sv
module fifo_offset_bank #(
  parameter int BYTE_W = 8,
  parameter int OFS_W  = 17
) (
  input  logic              clk,
  input  logic              mrst,
  input  logic              ld,
  input  logic              wen_n,
  input  logic              ren_n,
  input  logic              sen_n,
  input  logic              load_serial,
  input  logic              sin,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] dout,
  output logic              mem_we,
  output logic              mem_re,
  output logic              serial_mode,
  output logic [OFS_W-1:0]  empty_ofs,
  output logic [OFS_W-1:0]  full_ofs
);
  localparam int TOP_W   = OFS_W - 2*BYTE_W;
  localparam int CHAIN_W = 2*OFS_W;
  localparam logic [OFS_W-1:0] DEF_LO = {{TOP_W{1'b0}}, {2{1'b0, {(BYTE_W-1){1'b1}}}}};
  localparam logic [OFS_W-1:0] DEF_HI = '1;

  logic [CHAIN_W-1:0] chain;
  logic [2:0]         wr_slot, rd_slot;
  logic [BYTE_W-1:0]  rd_val;

  assign empty_ofs = chain[OFS_W-1:0];
  assign full_ofs  = chain[CHAIN_W-1:OFS_W];

  wire par_wr = !ld && !wen_n &&  ren_n && !serial_mode;
  wire par_rd = !ld &&  wen_n && !ren_n;
  wire shift  = !ld &&  wen_n &&  ren_n && !sen_n && serial_mode;

  assign mem_we = !mrst && ld && !wen_n;
  assign mem_re = !mrst && ld && !ren_n;

  function automatic logic [2:0] bump(input logic [2:0] s);
    return (s == 3'd5) ? 3'd0 : s + 3'd1;
  endfunction

  always_comb begin
    case (rd_slot)
      3'd0:    rd_val = empty_ofs[BYTE_W-1:0];
      3'd1:    rd_val = empty_ofs[2*BYTE_W-1:BYTE_W];
      3'd2:    rd_val = BYTE_W'(empty_ofs[OFS_W-1:2*BYTE_W]);
      3'd3:    rd_val = full_ofs[BYTE_W-1:0];
      3'd4:    rd_val = full_ofs[2*BYTE_W-1:BYTE_W];
      3'd5:    rd_val = BYTE_W'(full_ofs[OFS_W-1:2*BYTE_W]);
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (mrst) begin
      serial_mode <= load_serial;
      chain       <= ld ? {DEF_HI, DEF_HI} : {DEF_LO, DEF_LO};
      wr_slot     <= '0;
      rd_slot     <= '0;
      dout        <= '0;
    end else begin
      if (par_wr) begin
        case (wr_slot)
          3'd0: chain[BYTE_W-1:0]                    <= din;
          3'd1: chain[2*BYTE_W-1:BYTE_W]             <= din;
          3'd2: chain[OFS_W-1:2*BYTE_W]              <= din[TOP_W-1:0];
          3'd3: chain[OFS_W+BYTE_W-1:OFS_W]          <= din;
          3'd4: chain[OFS_W+2*BYTE_W-1:OFS_W+BYTE_W] <= din;
          3'd5: chain[CHAIN_W-1:OFS_W+2*BYTE_W]      <= din[TOP_W-1:0];
          default: ;
        endcase
        wr_slot <= bump(wr_slot);
      end else if (shift) begin
        chain <= {sin, chain[CHAIN_W-1:1]};
      end
      if (par_rd) begin
        dout    <= rd_val;
        rd_slot <= bump(rd_slot);
      end
    end
  end
endmodule

// File: rtl/fifo_offset_bank_chk.sv
module fifo_offset_bank_chk #(
  parameter int BYTE_W = 8,
  parameter int OFS_W  = 17
) (
  input logic              clk,
  input logic              mrst,
  input logic              ld,
  input logic              wen_n,
  input logic              ren_n,
  input logic              sen_n,
  input logic              sin,
  input logic              serial_mode,
  input logic              mem_we,
  input logic              mem_re,
  input logic [BYTE_W-1:0] dout,
  input logic [OFS_W-1:0]  empty_ofs,
  input logic [OFS_W-1:0]  full_ofs
);
  logic seen_rst = 1'b0;
  always_ff @(posedge clk) if (mrst) seen_rst <= 1'b1;
  wire live = seen_rst && !mrst;

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (mrst)
    live && $past(live) |-> $stable(serial_mode)); // R2
  AST_SER_NO_PAR: assert property (@(posedge clk) disable iff (mrst)
    live && serial_mode && !ld && !wen_n && ren_n |=> $stable(empty_ofs) && $stable(full_ofs)); // R4
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (mrst)
    live && !(!ld && wen_n && !ren_n) |=> $stable(dout)); // R5
  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (mrst)
    live && serial_mode && !ld && wen_n && ren_n && !sen_n |=>
      full_ofs[OFS_W-1] == $past(sin) && empty_ofs[OFS_W-1] == $past(full_ofs[0])); // R6
  AST_PAR_NO_SHIFT: assert property (@(posedge clk) disable iff (mrst)
    live && !serial_mode && !ld && wen_n && ren_n && !sen_n |=> $stable(empty_ofs) && $stable(full_ofs)); // R7
  AST_MEM_KEEPS: assert property (@(posedge clk) disable iff (mrst)
    live && ld |=> $stable(empty_ofs) && $stable(full_ofs)); // R8
  AST_NO_STROBE: assert property (@(posedge clk) disable iff (mrst)
    !ld |-> !mem_we && !mem_re); // R8
  AST_NOP: assert property (@(posedge clk) disable iff (mrst)
    live && !ld && wen_n && ren_n && sen_n |=> $stable(empty_ofs) && $stable(full_ofs) && $stable(dout)); // R9
endmodule

bind fifo_offset_bank fifo_offset_bank_chk #(.BYTE_W(BYTE_W), .OFS_W(OFS_W)) u_chk (
  .clk(clk), .mrst(mrst), .ld(ld), .wen_n(wen_n), .ren_n(ren_n), .sen_n(sen_n),
  .sin(sin), .serial_mode(serial_mode), .mem_we(mem_we), .mem_re(mem_re),
  .dout(dout), .empty_ofs(empty_ofs), .full_ofs(full_ofs));

// File: tb/tb_fifo_offset_bank.sv
`timescale 1ns/1ps
module tb_fifo_offset_bank;
  logic clk = 0, mrst = 1, ld = 0, wen_n = 1, ren_n = 1, sen_n = 1, load_serial = 0, sin = 0;
  logic [7:0] din = '0, dout;
  logic mem_we, mem_re, serial_mode;
  logic [16:0] empty_ofs, full_ofs;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [16:0] xe, xf;
  logic [7:0]  xd;
  int xwp, xrp;
  bit xser;

  always #2.5 clk = ~clk;

  fifo_offset_bank dut (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_state(input string tag);
    check({tag, " empty_ofs"}, 64'(empty_ofs), 64'(xe));
    check({tag, " full_ofs"},  64'(full_ofs),  64'(xf));
    check({tag, " dout"},      64'(dout),      64'(xd));
    check({tag, " serial_mode"}, 64'(serial_mode), 64'(xser));
  endtask

  function automatic logic [7:0] slot_val(input int s);
    case (s)
      0: return xe[7:0];
      1: return xe[15:8];
      2: return {7'd0, xe[16]};
      3: return xf[7:0];
      4: return xf[15:8];
      default: return {7'd0, xf[16]};
    endcase
  endfunction

  task automatic do_reset(input logic ldv, input logic ser);
    mrst = 1; ld = ldv; load_serial = ser; wen_n = 1; ren_n = 1; sen_n = 1;
    #1 check("R8 strobes low in reset", {62'd0, mem_we, mem_re}, 64'd0);
    @(posedge clk);
    @(negedge clk);
    mrst = 0; ld = 0;
    xe = ldv ? 17'h1FFFF : 17'h07F7F; xf = xe; xd = 0; xwp = 0; xrp = 0; xser = ser;
    check_state("R1 R2 reset");
  endtask

  task automatic op(input string tag, input logic l, input logic w, input logic r,
                    input logic s, input logic [7:0] d, input logic b);
    logic [33:0] c;
    ld = l; wen_n = w; ren_n = r; sen_n = s; din = d; sin = b;
    #1 check({tag, " R8 strobes"}, {62'd0, mem_we, mem_re}, {62'd0, l & ~w, l & ~r});
    @(posedge clk);
    if (!l && !w && r && !xser) begin
      case (xwp)
        0: xe[7:0] = d;
        1: xe[15:8] = d;
        2: xe[16] = d[0];
        3: xf[7:0] = d;
        4: xf[15:8] = d;
        default: xf[16] = d[0];
      endcase
      xwp = (xwp + 1) % 6;
    end else if (!l && w && r && !s && xser) begin
      c = {b, xf, xe[16:1]};
      xf = c[33:17]; xe = c[16:0];
    end
    if (!l && w && !r) begin
      xd = slot_val(xrp);
      xrp = (xrp + 1) % 6;
    end
    @(negedge clk);
    ld = 0; wen_n = 1; ren_n = 1; sen_n = 1;
    check_state(tag);
  endtask

  initial begin
    @(negedge clk);
    for (int lv = 0; lv < 2; lv++)
      for (int sm = 0; sm < 2; sm++) do_reset(lv[0], sm[0]);

    do_reset(1'b0, 1'b0);
    for (int i = 0; i < 12; i++) op("R3 parallel write", 0, 0, 1, 1, 8'(i * 37 + 5), 0);
    for (int i = 0; i < 12; i++) op("R5 parallel read", 0, 1, 0, 1, 8'h00, 0);
    load_serial = 1;
    op("R7 shift ignored in parallel", 0, 1, 1, 0, 8'h00, 1);
    op("R2 mode held", 0, 1, 1, 1, 8'h00, 0);
    for (int m = 0; m < 4; m++) op("R8 memory op", 1, m[0], m[1], 0, 8'hA5, 1);
    op("R9 nop sen high", 0, 1, 1, 1, 8'h3C, 1);
    op("R9 both enables low", 0, 0, 0, 0, 8'h3C, 1);
    for (int i = 0; i < 3; i++) op("R5 read after wrap", 0, 1, 0, 1, 8'h00, 0);

    do_reset(1'b1, 1'b1);
    load_serial = 0;
    for (int i = 0; i < 34; i++) op("R6 serial shift", 0, 1, 1, 0, 8'h00, 1'(((i * 7) >> 2) ^ i));
    for (int i = 0; i < 7; i++) op("R4 parallel write ignored", 0, 0, 1, 1, 8'h5A, 0);
    for (int i = 0; i < 7; i++) op("R5 read in serial mode", 0, 1, 0, 1, 8'h00, 0);
    op("R9 nop in serial", 0, 1, 1, 1, 8'h00, 1);
    op("R8 memory op in serial", 1, 0, 0, 0, 8'h00, 1);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule